// File: doc/BRIEF.md
# Manual-Scan Converter Serial Frame Controller

This block is the serial command port and channel sequencer of a sixteen-channel, 12-bit sampling converter in manual scan mode. A host frames each transfer with an active-low chip select and clocks sixteen serial clock cycles per frame. The block shifts in a 16-bit command, decodes it and keeps a fixed three-frame channel pipeline. A channel named in one frame is routed to the input multiplexer during the next frame and sampled when that frame ends. Its result is shifted back to the host in the frame after that.

The serial pins are sampled by the block's own system clock through a short synchronizer, so the serial clock must run well below the system clock. The conversion core is represented by a request/result port. The block pulses a request carrying the channel and range flag, and a stub returns a 12-bit result with a valid strobe. The block also drives a power-down flag and general-purpose output bits, and it reads general-purpose input bits for the alternative response format.

Top module: `mfc_top`

## Requirements
- R1: After reset the selected channel, range flag, response format, power-down flag, general-purpose outputs, stored result and stored result channel are all zero. The first response word is therefore 16'h0000, and no conversion request is pending.
- R2: A command is applied only if its bits [15:12] equal 4'b0001 and its frame had all 16 rising serial clock edges. Any other mode code leaves every command field and the channel select unchanged.
- R3: Command bit 11 set to 1 loads bits [6:0] of that frame (range, power-down, format, general-purpose outputs). Set to 0, those fields keep their previous values.
- R4: Command bits [10:7] give the next channel number in plain binary with bit 10 as MSB (0 to 15).
- R5: A channel selected in frame n is switched to the multiplexer on the 2nd falling serial clock edge of frame n+1. It is requested from the converter (one-cycle conv_req_o with that channel on conv_ch_o) when frame n+1 ends, and its result is shifted out in frame n+2.
- R6: Command bit 6 is the range flag (0 single reference, 1 double reference). The request issued at the end of a frame carries the range flag in force during that frame.
- R7: Command bit 5 drives pwr_dn_o. The new value takes effect on the 16th falling serial clock edge of the frame carrying it, and not before.
- R8: Response bits [11:0] hold the stored result. When the format bit (command bit 4) is 0, bits [15:12] hold the result's channel. When it is 1, they hold gpio_i[3:0] as sampled at the falling chip select.
- R9: Command bits [3:0] update gpio_o[3:0] only in the bit positions where gpio_dir_i is 1 (output). Other bits keep their value.
- R10: SDI is sampled on rising serial clock edges and SDO changes on falling edges, MSB first. sdo_oe_o is high only while chip select is low.
- R11: A frame that ends before 16 rising serial clock edges changes no command field, issues no conversion request and leaves the stored result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial command data |
| sdo_o | output | 1 | Serial response data |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| gpio_dir_i | input | 4 | Per-bit direction, 1 = output |
| gpio_i | input | 4 | General-purpose input levels |
| gpio_o | output | 4 | General-purpose output levels |
| pwr_dn_o | output | 1 | Power-down request |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_ch_o | output | 4 | Channel to convert |
| conv_range_o | output | 1 | Range flag for the request |
| conv_vld_i | input | 1 | Conversion result valid |
| conv_data_i | input | 12 | Conversion result |

## Verification
At the chip-select rise that closes a frame, the channel select register takes the new command in the same cycle that the sample request fires for the previous select. Back-to-back frames with a different channel in each provoke this. The request's channel is judged against the select of the frame before, never the one just received. Power-down similarly shares the final edge of a frame with the last response bit, so pwr_dn_o is compared both just before the 16th rising edge and after the frame ends.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned RES_W   = 12;
  localparam int unsigned CH_W    = 4;
  localparam int unsigned GPIO_W  = 4;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [3:0]  MODE_MANUAL = 4'b0001;

  // field order is decoded by the host: keep packed order
  typedef struct packed {
    logic [3:0]        mode;
    logic              prog;
    logic [CH_W-1:0]   ch;
    logic              range;
    logic              pdn;
    logic              fmt;
    logic [GPIO_W-1:0] gpio;
  } cmd_t;

  typedef struct packed {
    logic range;
    logic pdn;
    logic fmt;
  } low_t;
endpackage

// File: rtl/mfc_frame_rx.sv
module mfc_frame_rx
  import mfc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic active_o,
  output logic frame_start_o,
  output logic frame_end_o,
  output logic frame_ok_o,
  output logic sclk_fall_o,
  output logic fall2_o,
  output logic fall_last_o,
  output cmd_t cmd_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] cs_s, sclk_s, sdi_s;
  logic cs_d, sclk_d;
  logic cs_c, sclk_c, sdi_c;
  logic rise, fall;
  logic [CNT_W-1:0] rise_cnt, fall_cnt;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_s   <= '1;
      sclk_s <= '0;
      sdi_s  <= '0;
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_ni};
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk_i};
      sdi_s  <= {sdi_s[SYNC_STAGES-2:0], sdi_i};
      cs_d   <= cs_c;
      sclk_d <= sclk_c;
    end
  end

  assign cs_c   = cs_s[SYNC_STAGES-1];
  assign sclk_c = sclk_s[SYNC_STAGES-1];
  assign sdi_c  = sdi_s[SYNC_STAGES-1];

  assign active_o      = ~cs_c;
  assign frame_start_o = ~cs_c & cs_d;
  assign frame_end_o   = cs_c & ~cs_d;
  assign rise          = ~cs_c & sclk_c & ~sclk_d;
  assign fall          = ~cs_c & ~sclk_c & sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
      shreg    <= '0;
    end else if (frame_start_o) begin
      rise_cnt <= '0;
      fall_cnt <= '0;
    end else begin
      if (rise && rise_cnt != FULL) begin
        shreg    <= {shreg[FRAME_W-2:0], sdi_c};
        rise_cnt <= rise_cnt + 1'b1;
      end
      if (fall && fall_cnt != FULL) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  assign frame_ok_o  = (rise_cnt == FULL);
  assign sclk_fall_o = fall;
  assign fall2_o     = fall && (fall_cnt == CNT_W'(1));
  assign fall_last_o = fall && (fall_cnt == FULL - 1'b1) && (rise_cnt == FULL);
  assign cmd_o       = cmd_t'(shreg);

  // R10
  fall_le_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_cnt <= rise_cnt);
endmodule

// File: rtl/mfc_cmd_regs.sv
module mfc_cmd_regs
  import mfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic              frame_ok_i,
  input  logic              fall_last_i,
  input  cmd_t              cmd_i,
  input  logic [GPIO_W-1:0] gpio_dir_i,
  output logic [CH_W-1:0]   sel_ch_o,
  output logic              range_o,
  output logic              fmt_o,
  output logic              pdn_o,
  output logic [GPIO_W-1:0] gpio_o
);
  logic mode_ok, take;
  low_t low_q;
  logic [CH_W-1:0]   sel_q;
  logic [GPIO_W-1:0] gpio_q;
  logic              pdn_q;

  assign mode_ok = (cmd_i.mode == MODE_MANUAL);
  assign take    = frame_end_i & frame_ok_i & mode_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      low_q  <= '0;
      gpio_q <= '0;
    end else if (take) begin
      sel_q <= cmd_i.ch;
      if (cmd_i.prog) begin
        low_q  <= '{range: cmd_i.range, pdn: cmd_i.pdn, fmt: cmd_i.fmt};
        gpio_q <= (gpio_q & ~gpio_dir_i) | (cmd_i.gpio & gpio_dir_i);
      end
    end
  end

  // power-down acts on the last falling edge, ahead of the frame-end parse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pdn_q <= 1'b0;
    else if (fall_last_i && mode_ok) pdn_q <= cmd_i.prog ? cmd_i.pdn : low_q.pdn;
  end

  assign sel_ch_o = sel_q;
  assign range_o  = low_q.range;
  assign fmt_o    = low_q.fmt;
  assign pdn_o    = pdn_q;
  assign gpio_o   = gpio_q;

  // R2
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !mode_ok) |=> ($stable(sel_q) && $stable(low_q) && $stable(gpio_q)));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !cmd_i.prog) |=> ($stable(low_q) && $stable(gpio_q)));
  // R7
  pdn_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_last_i |=> $stable(pdn_q));
endmodule

// File: rtl/mfc_chan_pipe.sv
module mfc_chan_pipe
  import mfc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_W-1:0]  sel_ch_i,
  input  logic             range_i,
  input  logic             fall2_i,
  input  logic             frame_end_i,
  input  logic             frame_ok_i,
  input  logic             conv_vld_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             conv_req_o,
  output logic [CH_W-1:0]  conv_ch_o,
  output logic             conv_range_o,
  output logic [RES_W-1:0] res_o,
  output logic [CH_W-1:0]  res_ch_o
);
  logic [CH_W-1:0]  mux_q, pend_q, res_ch_q;
  logic [RES_W-1:0] res_q;
  logic             req_q, rng_q, sample;

  assign sample = frame_end_i & frame_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q    <= '0;
      pend_q   <= '0;
      rng_q    <= 1'b0;
      req_q    <= 1'b0;
      res_q    <= '0;
      res_ch_q <= '0;
    end else begin
      if (fall2_i) mux_q <= sel_ch_i;
      req_q <= sample;
      if (sample) begin
        pend_q <= mux_q;
        rng_q  <= range_i;
      end
      if (conv_vld_i) begin
        res_q    <= conv_data_i;
        res_ch_q <= pend_q;
      end
    end
  end

  assign conv_req_o   = req_q;
  assign conv_ch_o    = pend_q;
  assign conv_range_o = rng_q;
  assign res_o        = res_q;
  assign res_ch_o     = res_ch_q;

  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
  // R11
  short_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !frame_ok_i) |=> !conv_req_o);
  // R5
  req_ch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> ($stable(conv_ch_o) && $stable(conv_range_o)));
endmodule

// File: rtl/mfc_resp_tx.sv
module mfc_resp_tx
  import mfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              frame_start_i,
  input  logic              sclk_fall_i,
  input  logic              fmt_i,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic [CH_W-1:0]   res_ch_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [FRAME_W-1:0] shreg;
  logic               oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg <= '0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= active_i;
      if (frame_start_i)    shreg <= {(fmt_i ? gpio_i : res_ch_i), res_i};
      else if (sclk_fall_i) shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo_o    = shreg[FRAME_W-1];
  assign sdo_oe_o = oe_q;

  // R10
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_fall_i && !frame_start_i) |=> $stable(sdo_o));
endmodule

// File: rtl/mfc_top.sv
module mfc_top
  import mfc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [GPIO_W-1:0] gpio_dir_i,
  input  logic [GPIO_W-1:0] gpio_i,
  output logic [GPIO_W-1:0] gpio_o,
  output logic              pwr_dn_o,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  output logic              conv_range_o,
  input  logic              conv_vld_i,
  input  logic [RES_W-1:0]  conv_data_i
);
  logic active, f_start, f_end, f_ok, s_fall, fall2, fall_last;
  cmd_t cmd;
  logic [CH_W-1:0]  sel_ch, res_ch;
  logic             range, fmt;
  logic [RES_W-1:0] res;

  mfc_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdi_i,
    .active_o(active), .frame_start_o(f_start), .frame_end_o(f_end),
    .frame_ok_o(f_ok), .sclk_fall_o(s_fall), .fall2_o(fall2),
    .fall_last_o(fall_last), .cmd_o(cmd)
  );

  mfc_cmd_regs u_cmd (
    .clk_i, .rst_ni, .frame_end_i(f_end), .frame_ok_i(f_ok),
    .fall_last_i(fall_last), .cmd_i(cmd), .gpio_dir_i,
    .sel_ch_o(sel_ch), .range_o(range), .fmt_o(fmt), .pdn_o(pwr_dn_o),
    .gpio_o
  );

  mfc_chan_pipe u_pipe (
    .clk_i, .rst_ni, .sel_ch_i(sel_ch), .range_i(range), .fall2_i(fall2),
    .frame_end_i(f_end), .frame_ok_i(f_ok), .conv_vld_i, .conv_data_i,
    .conv_req_o, .conv_ch_o, .conv_range_o, .res_o(res), .res_ch_o(res_ch)
  );

  mfc_resp_tx u_tx (
    .clk_i, .rst_ni, .active_i(active), .frame_start_i(f_start),
    .sclk_fall_i(s_fall), .fmt_i(fmt), .gpio_i, .res_i(res),
    .res_ch_i(res_ch), .sdo_o, .sdo_oe_o
  );
endmodule

// File: tb/sim_mfc_top.sv
module sim_mfc_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [3:0] gdir = 4'hF, gin = 4'h6;
  logic sdo, oe, pd, creq, crng, cvld = 1'b0;
  logic [3:0] gout, cch;
  logic [11:0] cdata = '0;

  int compared = 0, mismatched = 0, cyc = 0, req_cnt = 0, cs_hi = 0;
  logic [3:0] last_ch = '0;
  logic last_rng = 1'b0;
  bit done = 1'b0;

  // behavioural model state
  logic [3:0] sel_m = 0, resch_m = 0, gpo_m = 0;
  logic rng_m = 0, fmt_m = 0, pd_m = 0;
  logic [11:0] res_m = 0;

  always #10 clk = ~clk;

  mfc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe), .gpio_dir_i(gdir), .gpio_i(gin),
    .gpio_o(gout), .pwr_dn_o(pd), .conv_req_o(creq), .conv_ch_o(cch),
    .conv_range_o(crng), .conv_vld_i(cvld), .conv_data_i(cdata)
  );

  function automatic logic [11:0] fdata(logic [3:0] c, logic r);
    return 12'({8'd0, c} * 12'd173 + (r ? 12'd2048 : 12'd0) + 12'd5);
  endfunction

  function automatic logic [15:0] cmd(logic [3:0] mode, logic prog, logic [3:0] ch,
                                      logic rng, logic pdn, logic fmt, logic [3:0] gp);
    return {mode, prog, ch, rng, pdn, fmt, gp};
  endfunction

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter stub and request monitor
  always @(posedge clk) begin
    cvld <= creq;
    cs_hi <= cs_n ? cs_hi + 1 : 0;
    if (creq) begin
      cdata    <= fdata(cch, crng);
      req_cnt  <= req_cnt + 1;
      last_ch  <= cch;
      last_rng <= crng;
    end
  end

  // R10: drive enable stays off while chip select has been high
  always @(negedge clk)
    if (rst_n && cs_hi > 4) chk("R10 sdo_oe idle", int'(oe), 0);

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_frame(logic [15:0] w, int nbits, string tag);
    logic [15:0] exp;
    logic [3:0]  old_sel;
    logic        old_rng, pd_old;
    int          rc0;
    exp     = {(fmt_m ? gin : resch_m), res_m};
    old_sel = sel_m;
    old_rng = rng_m;
    pd_old  = pd_m;
    rc0     = req_cnt;
    cs_n = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15-i];
      wait_clk(3);
      chk({tag, " R5 R8 R10 sdo bit"}, int'(sdo), int'(exp[15-i]));
      chk({tag, " R10 sdo_oe active"}, int'(oe), 1);
      if (i == 15) chk({tag, " R7 pwr_dn before 16th fall"}, int'(pd), int'(pd_old));
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
      wait_clk(3);
    end
    wait_clk(3);
    cs_n = 1'b1;
    wait_clk(12);
    if (nbits == 16) begin
      chk({tag, " R5 request count"}, req_cnt - rc0, 1);
      chk({tag, " R5 request channel"}, int'(last_ch), int'(old_sel));
      chk({tag, " R6 request range"}, int'(last_rng), int'(old_rng));
      res_m   = fdata(old_sel, old_rng);
      resch_m = old_sel;
      if (w[15:12] == 4'b0001) begin
        sel_m = w[10:7];
        if (w[11]) begin
          rng_m = w[6];
          pd_m  = w[5];
          fmt_m = w[4];
          gpo_m = (gpo_m & ~gdir) | (w[3:0] & gdir);
        end
      end
    end else begin
      chk({tag, " R11 no request"}, req_cnt - rc0, 0);
    end
    chk({tag, " R9 gpio_o"}, int'(gout), int'(gpo_m));
    chk({tag, " R7 pwr_dn after frame"}, int'(pd), int'(pd_m));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1 sdo_oe", int'(oe), 0);
    chk("R1 pwr_dn", int'(pd), 0);
    chk("R1 gpio_o", int'(gout), 0);
    chk("R1 conv_req", int'(creq), 0);
    do_frame(cmd(4'd1, 1, 4'd4,  0, 0, 0, 4'hA), 16, "R1 R4");
    do_frame(cmd(4'd1, 1, 4'd7,  1, 0, 0, 4'h3), 16, "R4 R6");
    do_frame(cmd(4'd1, 1, 4'd9,  0, 0, 0, 4'h5), 16, "R5");
    do_frame(cmd(4'd1, 0, 4'd15, 1, 1, 1, 4'hF), 16, "R3");
    do_frame(cmd(4'd1, 0, 4'd0,  1, 1, 1, 4'hF), 16, "R3 R4");
    do_frame(cmd(4'd2, 1, 4'd3,  1, 1, 1, 4'h0), 16, "R2");
    do_frame(cmd(4'd1, 1, 4'd12, 0, 1, 0, 4'h9), 16, "R7");
    do_frame(cmd(4'd1, 1, 4'd5,  1, 0, 1, 4'h0), 9,  "R11");
    do_frame(cmd(4'd1, 1, 4'd5,  1, 0, 1, 4'h0), 1,  "R11");
    do_frame(cmd(4'd1, 1, 4'd2,  0, 0, 1, 4'hC), 16, "R8 R7");
    gdir = 4'b0101;
    do_frame(cmd(4'd1, 1, 4'd8,  0, 0, 1, 4'hF), 16, "R9");
    do_frame(cmd(4'd1, 1, 4'd1,  0, 0, 0, 4'h0), 16, "R9");
    gin = 4'h9;
    do_frame(cmd(4'd1, 0, 4'd6,  0, 0, 0, 4'h0), 16, "R8");
    do_frame(cmd(4'd1, 1, 4'd0,  1, 0, 1, 4'h0), 16, "R6");
    do_frame(cmd(4'd1, 1, 4'd0,  0, 0, 0, 4'h0), 16, "R5");
    do_frame(cmd(4'd1, 1, 4'd0,  0, 0, 0, 4'h0), 16, "R5");
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule